// File: doc/BRIEF.md
# Two-Stage SCL Timing Divider

This block produces the bit timing for an I2C master. A single 8-bit divider value holds two fields. The low two bits are a prescale P that slows the module clock down to an internal tick rate of one tick every P+1 module cycles. The upper six bits are a gate value G that sets the SCL period to 8·G + 20 internal ticks. That period is split into a low half and a high half of 4·G + 10 ticks each. The internal tick rate must stay under 20 MHz, so a module clock near 33 MHz needs a prescale of at least 1. Software picks the divider value; this block only applies it.

When the master raises `busy_i`, the block marks out the low and high phases of SCL with two enables. It also pulses a quarter-period tick in the middle of each half. The shifter uses this tick to sample SDA in the high half and to change SDA in the low half. During the high half the phase counter stops while the sensed SCL line is held low, so a slave can stretch the clock. A new divider value written while the master runs is held back until the current SCL period ends. A value written while idle takes effect at once.

Top module: `scl_clkdiv`

## Requirements
- R1: After reset, `scl_lo_en`, `scl_hi_en` and `qtr_tick` are low and `div_o` reads 0.
- R2: The prescale field P is `div_wdata[1:0]`. Internal ticks occur once every P+1 module cycles, so every phase length scales by P+1.
- R3: The gate field G is `div_wdata[7:2]`. The low phase lasts (P+1)·(4·G+10) module cycles.
- R4: With `scl_in` high, the high phase lasts (P+1)·(4·G+10) module cycles. The whole SCL period lasts (P+1)·(8·G+20) cycles.
- R5: `qtr_tick` pulses exactly once in each phase. In an unstretched phase it comes (P+1)·(2·G+5)−1 cycles after the first cycle of the phase.
- R6: In the high phase, every internal tick that arrives while `scl_in` is low is not counted. With P=0, holding `scl_in` low for S cycles lengthens the high phase by S cycles and delays its `qtr_tick` by S cycles.
- R7: A write while the master runs leaves the current SCL period unchanged. `div_o` shows the new value from the first cycle of the next period, and that period uses it.
- R8: A write while idle is visible on `div_o` in the next cycle.
- R9: While `busy_i` is low, both enables and `qtr_tick` stay low. One cycle after `busy_i` rises, `scl_lo_en` is high.
- R10: The value of `scl_in` has no effect during the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Master is running a transfer |
| div_we | input | 1 | Write strobe for the divider value |
| div_wdata | input | 8 | New divider value: gate in [7:2], prescale in [1:0] |
| scl_in | input | 1 | Sensed level of the SCL line |
| div_o | output | 8 | Divider value currently in use |
| scl_lo_en | output | 1 | SCL low phase in progress |
| scl_hi_en | output | 1 | SCL high phase in progress |
| qtr_tick | output | 1 | One-cycle pulse at the middle of each phase |

## Verification
The in-line assertions check on every cycle that:
- the prescale and phase counters stay within the bounds set by the divider value in use;
- the value in use never changes in the middle of a running period;
- the phase counter freezes while a stretch is seen in the high phase;
- the low-phase counter keeps advancing whatever `scl_in` does;
- the outputs stay quiet while idle.

Only the bench's scenarios can show that the cycle counts are right. It measures the exact phase lengths and the tick positions over random and extreme divider values, the extra length that a stretch adds, and the one-period delay before a value written during a transfer takes effect.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    typedef struct packed {
        logic run;
    } top_state_t;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             period_end,
    output logic [DIV_W-1:0] active_o
);
    typedef struct packed {
        logic [DIV_W-1:0] active;
        logic [DIV_W-1:0] pend;
        logic             pend_vld;
    } cfg_state_t;

    cfg_state_t q, d;

    always_comb begin
        d = q;
        // a pending value moves in at a period boundary or once idle
        if ((!run || period_end) && q.pend_vld) begin
            d.active   = q.pend;
            d.pend_vld = 1'b0;
        end
        if (wr_en) begin
            if (!run) begin
                d.active   = wr_data;
                d.pend_vld = 1'b0;
            end else begin
                d.pend     = wr_data;
                d.pend_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o = q.active;

    p_hold_mid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !period_end) |=> $stable(active_o));
    p_idle_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en) |=> (active_o == $past(wr_data)));
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             ce
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t q, d;

    always_comb begin
        ce = run && (q.cnt == pre);
        d  = q;
        if (!run || ce) d.cnt = '0;
        else            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= pre));
endmodule

// File: rtl/scl_phase.sv
module scl_phase
    import scl_div_pkg::*;
#(
    parameter int GATE_W    = 6,
    parameter int CNT_W     = 9,
    parameter int HALF_BASE = 10,
    parameter int HALF_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ce,
    input  logic [GATE_W-1:0] gate,
    input  logic              scl_in,
    output logic              lo_en,
    output logic              hi_en,
    output logic              qtr_tick,
    output logic              period_end
);
    typedef struct packed {
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } ph_state_t;

    ph_state_t        q, d;
    logic [CNT_W-1:0] half_last;
    logic [CNT_W-1:0] mid_last;
    logic             stall;
    logic             adv;
    logic             wrap;

    always_comb begin
        half_last  = CNT_W'(HALF_STEP) * CNT_W'(gate) + CNT_W'(HALF_BASE - 1);
        mid_last   = half_last >> 1;
        stall      = (q.phase == PH_HIGH) && !scl_in;
        adv        = run && ce && !stall;
        wrap       = adv && (q.cnt == half_last);
        qtr_tick   = adv && (q.cnt == mid_last);
        period_end = wrap && (q.phase == PH_HIGH);
        lo_en      = run && (q.phase == PH_LOW);
        hi_en      = run && (q.phase == PH_HIGH);

        d = q;
        if (!run) begin
            d.phase = PH_LOW;
            d.cnt   = '0;
        end else if (wrap) begin
            d.phase = (q.phase == PH_LOW) ? PH_HIGH : PH_LOW;
            d.cnt   = '0;
        end else if (adv) begin
            d.cnt   = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_LOW, cnt: '0};
        else        q <= d;
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= half_last));
    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.phase == PH_HIGH && !scl_in) |=> (!run || $stable(q.cnt)));
    p_low_advances_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.phase == PH_LOW && ce) |=> (!run || !$stable(q.cnt)));
endmodule

// File: rtl/scl_clkdiv.sv
module scl_clkdiv
    import scl_div_pkg::*;
#(
    parameter int PRE_W     = 2,
    parameter int GATE_W    = 6,
    parameter int HALF_BASE = 10,
    parameter int HALF_STEP = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy_i,
    input  logic                      div_we,
    input  logic [PRE_W+GATE_W-1:0]   div_wdata,
    input  logic                      scl_in,
    output logic [PRE_W+GATE_W-1:0]   div_o,
    output logic                      scl_lo_en,
    output logic                      scl_hi_en,
    output logic                      qtr_tick
);
    localparam int DIV_W    = PRE_W + GATE_W;
    localparam int HALF_MAX = HALF_STEP * ((1 << GATE_W) - 1) + HALF_BASE;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    top_state_t       q, d;
    logic [DIV_W-1:0] active;
    logic             ce;
    logic             period_end;

    always_comb begin
        d     = q;
        d.run = busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    scl_div_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (q.run),
        .wr_en      (div_we),
        .wr_data    (div_wdata),
        .period_end (period_end),
        .active_o   (active)
    );

    scl_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.run),
        .pre   (active[PRE_W-1:0]),
        .ce    (ce)
    );

    scl_phase #(
        .GATE_W    (GATE_W),
        .CNT_W     (CNT_W),
        .HALF_BASE (HALF_BASE),
        .HALF_STEP (HALF_STEP)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (q.run),
        .ce         (ce),
        .gate       (active[DIV_W-1:PRE_W]),
        .scl_in     (scl_in),
        .lo_en      (scl_lo_en),
        .hi_en      (scl_hi_en),
        .qtr_tick   (qtr_tick),
        .period_end (period_end)
    );

    assign div_o = active;

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.run |-> !(scl_lo_en || scl_hi_en || qtr_tick));
    p_start_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.run) |-> scl_lo_en);
endmodule

// File: tb/sim_scl_clkdiv.sv
`timescale 1ns/1ps
module sim_scl_clkdiv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = 8'h00;
    logic       scl_in = 1'b1;
    logic [7:0] div_o;
    logic       scl_lo_en, scl_hi_en, qtr_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scl_clkdiv u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .div_we(div_we),
        .div_wdata(div_wdata), .scl_in(scl_in), .div_o(div_o),
        .scl_lo_en(scl_lo_en), .scl_hi_en(scl_hi_en), .qtr_tick(qtr_tick)
    );

    function automatic int exp_half(int p, int g);
        return (p + 1) * (4 * g + 10);
    endfunction

    function automatic int exp_tick(int p, int g);
        return (p + 1) * (2 * g + 5) - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_div(input int p, input int g);
        div_we    = 1'b1;
        div_wdata = {g[5:0], p[1:0]};
        @(negedge clk);
        div_we    = 1'b0;
    endtask

    task automatic measure(input int stretch, input bit wiggle, input bit do_wr,
                           input logic [7:0] wr_val,
                           output int lo_len, output int lo_tk, output int lo_nt,
                           output int hi_len, output int hi_tk, output int hi_nt);
        bit prev;
        lo_len = 0; lo_tk = -1; lo_nt = 0;
        hi_len = 0; hi_tk = -1; hi_nt = 0;
        prev = scl_lo_en;
        forever begin
            @(negedge clk);
            if (scl_lo_en && !prev) break;
            prev = scl_lo_en;
        end
        while (scl_lo_en) begin
            if (wiggle) scl_in = 1'($urandom % 2);
            if (do_wr && lo_len == 2) begin div_we = 1'b1; div_wdata = wr_val; end
            else div_we = 1'b0;
            if (qtr_tick) begin lo_tk = lo_len; lo_nt++; end
            lo_len++;
            @(negedge clk);
        end
        div_we = 1'b0;
        while (scl_hi_en) begin
            scl_in = (hi_len < stretch) ? 1'b0 : 1'b1;
            if (qtr_tick) begin hi_tk = hi_len; hi_nt++; end
            hi_len++;
            @(negedge clk);
        end
        scl_in = 1'b1;
    endtask

    task automatic verify(input int p, input int g, input int stretch, input bit wiggle);
        int ll, lt, ln, hl, ht, hn;
        measure(stretch, wiggle, 1'b0, 8'h00, ll, lt, ln, hl, ht, hn);
        check(wiggle ? "R3/R10 low length" : "R3 low length", ll, exp_half(p, g));
        check("R5 low tick position", lt, exp_tick(p, g));
        check("R5 low tick count", ln, 1);
        check("R4 high length", hl, exp_half(p, g) + stretch);
        check("R5 high tick position", ht, exp_tick(p, g) + stretch);
        check("R5 high tick count", hn, 1);
        check("R2/R4 period", ll + hl, (p + 1) * (8 * g + 20) + stretch);
    endtask

    task automatic start_cfg(input int p, input int g);
        busy_i = 1'b0;
        repeat (3) @(negedge clk);
        write_div(p, g);
        busy_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ll, lt, ln, hl, ht, hn;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 lo_en", int'(scl_lo_en), 0);
        check("R1 hi_en", int'(scl_hi_en), 0);
        check("R1 tick", int'(qtr_tick), 0);
        check("R1 div_o", int'(div_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 idle quiet, scl_in toggling
        for (int i = 0; i < 20; i++) begin
            scl_in = 1'($urandom % 2);
            @(negedge clk);
            check("R9 idle outputs", int'(scl_lo_en | scl_hi_en | qtr_tick), 0);
        end
        scl_in = 1'b1;

        // R8 idle write immediate: P=2, G=2
        div_we = 1'b1; div_wdata = {6'd2, 2'd2};
        @(negedge clk);
        div_we = 1'b0;
        check("R8 idle write", int'(div_o), int'({6'd2, 2'd2}));

        // R9 start: low phase one cycle after busy rises
        busy_i = 1'b1;
        @(negedge clk);
        check("R9 start low", int'(scl_lo_en), 1);
        // first period already begun; measure following one
        verify(2, 2, 0, 1'b0);

        // directed corners
        start_cfg(0, 0);  verify(0, 0, 0, 1'b0);
        start_cfg(3, 63); verify(3, 63, 0, 1'b1);
        start_cfg(0, 5);  verify(0, 5, 12, 1'b0);   // R6 stretch
        start_cfg(0, 0);  verify(0, 0, 3, 1'b1);    // R6 stretch, minimum gate

        // random configurations
        for (int i = 0; i < 12; i++) begin
            int p, g, s;
            p = int'($urandom % 4);
            g = int'($urandom % 32);
            s = (p == 0) ? int'($urandom % 8) : 0;
            start_cfg(p, g);
            verify(p, g, s, 1'($urandom % 2));
        end

        // R7 write during a running period
        start_cfg(1, 3);
        measure(0, 1'b0, 1'b1, {6'd7, 2'd0}, ll, lt, ln, hl, ht, hn);
        check("R7 current low unchanged", ll, exp_half(1, 3));
        check("R7 current high unchanged", hl, exp_half(1, 3));
        check("R7 div_o at next period", int'(div_o), int'({6'd7, 2'd0}));
        measure(0, 1'b0, 1'b0, 8'h00, ll, lt, ln, hl, ht, hn);
        check("R7 next low uses new value", ll, exp_half(0, 7));
        check("R7 next high uses new value", hl, exp_half(0, 7));

        // R9 return to idle
        busy_i = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R9 idle after run", int'(scl_lo_en | scl_hi_en | qtr_tick), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule